// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block runs one mailbox command against a register-mapped target that sits behind an I2C master. It has no bit-level bus logic of its own. Instead it issues a sequence of transfer requests on a simple transaction port and waits for each one to complete. Every request carries a 32-bit internal target address, a byte count, a direction and a data source. Chunk data moves between the I2C master and a local mailbox buffer, and the request names the byte offset within that buffer. The short register transfers carry their payload word on the port itself.

A command starts with a single-cycle `start` pulse while the block is idle. The block derives the payload length from the header field of the input mailbox and copies the input mailbox to the target in chunks. It then writes the prepare block of the command interface register and writes the GO word to fire the command. Next it polls the control word until the busy bit clears and checks the completion status. If the caller asked for output, the block finally reads the output mailbox back in chunks. Chunk transfers and polls are retried until a cycle timeout expires, plus a fixed number of extra attempts. The result is reported on a two-bit error code together with a one-cycle `done` pulse.

Top module: `mbx_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done` and `tx_req` are 0 and `err` is 0.
- R2: The payload length is 4 times the low 11 bits of `hdr_word`, plus 16. The upper 5 bits are ignored. The input mailbox is written as ceil(length/32) transfers with `tx_rnw`=0 and `tx_from_buf`=1. Each transfer is 32 bytes, except the last, which carries the remainder. Chunk k goes to address `in_off` plus the bytes already sent, with `tx_buf_off` equal to that same byte count.
- R3: The prepare step writes 28 bytes at address 0x72000. `tx_wdata` holds the final big-endian word, which is the opcode with bit 12 set exactly when `imm`=1. The 24 bytes before that word are zero.
- R4: The fire step writes 4 bytes at 0x72018, with `tx_wdata` equal to the prepare word with bit 23 set.
- R5: The poll step reads 4 bytes at 0x72018 and repeats while `tx_rdata[23]`=1. Once bit 23 reads 0, `status` takes `tx_rdata[31:24]`. A nonzero status ends the command with `err`=3 and no readback.
- R6: With `rd_out`=1, `imm`=0 and status 0, the output mailbox is read back with the R2 chunking from `out_off`, with `tx_rnw`=1. With `rd_out`=0 there is no readback and `err`=0.
- R7: With `imm`=1, no input chunks are written and no output is read back. The command is prepare, fire and poll only.
- R8: A chunk transfer or poll that fails (`tx_err`=1, or for a poll a set busy bit) is retried. Retries continue while the per-step cycle timer is below the limit, followed by exactly 5 more attempts. Exhaustion gives `err`=1 for a chunk and `err`=2 for a poll.
- R9: A failed prepare or fire transfer ends the command at once with `err`=1, and no later step is issued.
- R10: `busy` is 1 from the cycle after `start` through the `done` cycle. `done` is a one-cycle pulse, and `start` while busy is ignored.
- R11: `tx_req` stays high with stable fields until `tx_done`, and is low in the cycle after each `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (accepted when idle) |
| imm | input | 1 | Immediate query command |
| rd_out | input | 1 | Read the output mailbox back |
| opcode | input | OPC_W | Command opcode |
| hdr_word | input | 16 | Big-endian header word at mailbox byte 16 |
| in_off | input | OFF_W | Target address of the input mailbox |
| out_off | input | OFF_W | Target address of the output mailbox |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one cycle) |
| err | output | 2 | 0 ok, 1 transfer, 2 timeout, 3 bad status |
| status | output | 8 | Completion status from the control word |
| tx_req | output | 1 | Transfer request |
| tx_rnw | output | 1 | 1 read, 0 write |
| tx_addr | output | 32 | Internal target address |
| tx_len | output | CW | Data byte count |
| tx_from_buf | output | 1 | Data from/to local mailbox buffer |
| tx_buf_off | output | LEN_W | Mailbox buffer byte offset |
| tx_wdata | output | 32 | Register word for prepare/fire |
| tx_done | input | 1 | Transfer finished (one cycle) |
| tx_err | input | 1 | Transfer failed (with tx_done) |
| tx_rdata | input | 32 | Read word for polls |

## Verification
The assertions assume that the I2C master raises `tx_done` only while `tx_req` is high and only as a single-cycle pulse. They also assume that `tx_err` and `tx_rdata` are meaningful only in that cycle. The bench's responder model waits for a request, holds its answer for a fixed latency and then drops `tx_done` on the next cycle, so it keeps within these assumptions. It also pulses `start` during a running command only to confirm that the pulse is ignored.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_WCHUNK, S_PREP, S_FIRE, S_POLL, S_RCHUNK, S_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0, ERR_XFER = 2'd1, ERR_TIMEOUT = 2'd2, ERR_STATUS = 2'd3
    } seq_err_e;

    localparam logic [31:0] CIR_BASE   = 32'h0007_2000;
    localparam logic [31:0] CIR_CTRL   = CIR_BASE + 32'h18;
    localparam int          GO_BIT     = 23;
    localparam int          IMM_BIT    = 12;
    localparam int          PREP_BYTES = 28;
    localparam int          WORD_BYTES = 4;
    localparam int          HDR_BYTES  = 16;
    localparam int          FIELD_W    = 11;
endpackage

// File: rtl/mbx_chunker.sv
module mbx_chunker #(
    parameter int unsigned LEN_W     = 14,
    parameter int unsigned CHUNK_MAX = 32,
    parameter int unsigned CW        = 6
) (
    input  logic [15:0]      hdr_word,
    input  logic [LEN_W-1:0] remain,
    output logic [LEN_W-1:0] pay_len,
    output logic [CW-1:0]    chunk_len
);
    import mbx_seq_pkg::*;

    logic [4:0] unused_hdr;
    assign unused_hdr = hdr_word[15:FIELD_W];

    // Length in bytes: word count times four, plus the fixed header.
    assign pay_len   = LEN_W'({hdr_word[FIELD_W-1:0], 2'b00}) + LEN_W'(HDR_BYTES);
    assign chunk_len = (remain > LEN_W'(CHUNK_MAX)) ? CW'(CHUNK_MAX) : CW'(remain);
endmodule

// File: rtl/mbx_retry.sv
module mbx_retry #(
    parameter longint unsigned LIM     = 1,
    parameter int unsigned     RETRIES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fail,
    output logic may_retry
);
    localparam int TMR_W = $clog2(LIM + 2);
    localparam int RC_W  = $clog2(RETRIES + 1);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [RC_W-1:0]  extra;
    } rt_t;

    rt_t  d, q;
    logic expired;

    assign expired   = (q.tmr >= TMR_W'(LIM));
    assign may_retry = !expired || (q.extra < RC_W'(RETRIES));

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (!expired) d.tmr = q.tmr + 1'b1;
            if (fail && expired && (q.extra < RC_W'(RETRIES))) d.extra = q.extra + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: extra attempts are spent only after the timer has run out
    assert_no_early_spend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr && !expired) |=> (q.extra == $past(q.extra)));
endmodule

// File: rtl/mbx_cmd_seq.sv
module mbx_cmd_seq #(
    parameter int unsigned CLK_KHZ    = 250000,
    parameter int unsigned TIMEOUT_MS = 5000,
    parameter int unsigned RETRIES    = 5,
    parameter int unsigned CHUNK_MAX  = 32,
    parameter int unsigned OFF_W      = 20,
    parameter int unsigned OPC_W      = 12,
    localparam int unsigned CW        = $clog2(CHUNK_MAX + 1),
    localparam int unsigned LEN_W     = mbx_seq_pkg::FIELD_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             imm,
    input  logic             rd_out,
    input  logic [OPC_W-1:0] opcode,
    input  logic [15:0]      hdr_word,
    input  logic [OFF_W-1:0] in_off,
    input  logic [OFF_W-1:0] out_off,
    output logic             busy,
    output logic             done,
    output logic [1:0]       err,
    output logic [7:0]       status,
    output logic             tx_req,
    output logic             tx_rnw,
    output logic [31:0]      tx_addr,
    output logic [CW-1:0]    tx_len,
    output logic             tx_from_buf,
    output logic [LEN_W-1:0] tx_buf_off,
    output logic [31:0]      tx_wdata,
    input  logic             tx_done,
    input  logic             tx_err,
    input  logic [31:0]      tx_rdata
);
    import mbx_seq_pkg::*;

    // Timeout in cycles; the defaults give five seconds at 250 MHz.
    localparam longint unsigned LIM_CYC = 64'(CLK_KHZ) * 64'(TIMEOUT_MS);

    typedef struct packed {
        seq_state_e       state;
        logic             gap;
        logic             imm;
        logic             rdo;
        logic [OPC_W-1:0] opc;
        logic [OFF_W-1:0] ioff;
        logic [OFF_W-1:0] ooff;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] remain;
        seq_err_e         err;
        logic [7:0]       status;
    } seq_t;

    seq_t d, q;

    logic [LEN_W-1:0] pay_len, moved;
    logic [CW-1:0]    chunk_len;
    logic             r_clr, r_fail, may_retry, xfer_end, in_xfer;
    logic [31:0]      cmd_word;
    logic [22:0]      unused_rdata;

    assign unused_rdata = tx_rdata[22:0];

    mbx_chunker #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX), .CW(CW)) u_chunk (
        .hdr_word (hdr_word),
        .remain   (q.remain),
        .pay_len  (pay_len),
        .chunk_len(chunk_len)
    );

    mbx_retry #(.LIM(LIM_CYC), .RETRIES(RETRIES)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (r_clr),
        .fail     (r_fail),
        .may_retry(may_retry)
    );

    assign in_xfer  = (q.state == S_WCHUNK) || (q.state == S_PREP) || (q.state == S_FIRE) ||
                      (q.state == S_POLL)   || (q.state == S_RCHUNK);
    assign tx_req   = in_xfer && !q.gap;
    assign xfer_end = tx_req && tx_done;
    assign moved    = q.len - q.remain;
    assign cmd_word = 32'(q.opc) | (32'(q.imm) << IMM_BIT);

    always_comb begin
        d      = q;
        d.gap  = 1'b0;
        r_clr  = 1'b0;
        r_fail = 1'b0;
        unique case (q.state)
            S_IDLE: if (start) begin
                d.imm    = imm;
                d.rdo    = rd_out;
                d.opc    = opcode;
                d.ioff   = in_off;
                d.ooff   = out_off;
                d.len    = pay_len;
                d.remain = pay_len;
                d.err    = ERR_NONE;
                d.status = '0;
                r_clr    = 1'b1;
                d.state  = imm ? S_PREP : S_WCHUNK;
            end
            S_WCHUNK, S_RCHUNK: if (xfer_end) begin
                d.gap = 1'b1;
                if (!tx_err) begin
                    d.remain = q.remain - LEN_W'(chunk_len);
                    r_clr    = 1'b1;
                    if (q.remain == LEN_W'(chunk_len))
                        d.state = (q.state == S_WCHUNK) ? S_PREP : S_FINISH;
                end else begin
                    r_fail = 1'b1;
                    if (!may_retry) begin
                        d.err   = ERR_XFER;
                        d.state = S_FINISH;
                    end
                end
            end
            S_PREP, S_FIRE: if (xfer_end) begin
                d.gap = 1'b1;
                if (tx_err) begin
                    d.err   = ERR_XFER;
                    d.state = S_FINISH;
                end else if (q.state == S_PREP) begin
                    d.state = S_FIRE;
                end else begin
                    r_clr   = 1'b1;
                    d.state = S_POLL;
                end
            end
            S_POLL: if (xfer_end) begin
                d.gap = 1'b1;
                if (!tx_err && !tx_rdata[GO_BIT]) begin
                    d.status = tx_rdata[31:24];
                    r_clr    = 1'b1;
                    if (tx_rdata[31:24] != 8'd0) begin
                        d.err   = ERR_STATUS;
                        d.state = S_FINISH;
                    end else if (q.imm || !q.rdo) begin
                        d.state = S_FINISH;
                    end else begin
                        d.remain = q.len;
                        d.state  = S_RCHUNK;
                    end
                end else begin
                    r_fail = 1'b1;
                    if (!may_retry) begin
                        d.err   = ERR_TIMEOUT;
                        d.state = S_FINISH;
                    end
                end
            end
            S_FINISH: d.state = S_IDLE;
            default:  d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        tx_rnw      = (q.state == S_POLL) || (q.state == S_RCHUNK);
        tx_from_buf = (q.state == S_WCHUNK) || (q.state == S_RCHUNK);
        tx_buf_off  = moved;
        tx_wdata    = '0;
        tx_len      = CW'(WORD_BYTES);
        tx_addr     = CIR_CTRL;
        unique case (q.state)
            S_WCHUNK: begin tx_len = chunk_len; tx_addr = 32'(q.ioff) + 32'(moved); end
            S_RCHUNK: begin tx_len = chunk_len; tx_addr = 32'(q.ooff) + 32'(moved); end
            S_PREP:   begin tx_len = CW'(PREP_BYTES); tx_addr = CIR_BASE; tx_wdata = cmd_word; end
            S_FIRE:   tx_wdata = cmd_word | (32'd1 << GO_BIT);
            default:  ;
        endcase
    end

    assign busy   = (q.state != S_IDLE);
    assign done   = (q.state == S_FINISH);
    assign err    = q.err;
    assign status = q.status;

    // R11: an open request holds its fields until the master answers
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done) |=> (tx_req && $stable(tx_addr) && $stable(tx_len) && $stable(tx_rnw)));
    // R11: one idle cycle after each completed transfer
    assert_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_done) |=> !tx_req);
    // R2: chunk sizes stay within one block
    assert_chunk_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_from_buf) |-> (tx_len != '0 && tx_len <= CW'(CHUNK_MAX)));
    // R10: done returns the block to idle
    assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R10: no transfer while idle
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_req);
    // R5: a status error carries a nonzero status, a clean end a zero one
    assert_status_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((err == ERR_STATUS) == (status != 8'd0)));
endmodule

// File: tb/tb_mbx_cmd_seq.sv
`timescale 1ns/1ps
module tb_mbx_cmd_seq;
    localparam int LIM = 30;

    typedef struct packed {
        logic [15:0] hdr;
        logic        imm;
        logic        rdo;
        logic [11:0] opc;
        logic [7:0]  wfail;
        logic [7:0]  busyn;
        logic [7:0]  stat;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{16'h0000, 1'b0, 1'b1, 12'h040, 8'd0, 8'd0, 8'h00},
        '{16'h0004, 1'b0, 1'b0, 12'h123, 8'd0, 8'd1, 8'h00},
        '{16'h0005, 1'b0, 1'b1, 12'h201, 8'd0, 8'd3, 8'h00},
        '{16'hF80A, 1'b0, 1'b1, 12'h7AB, 8'd0, 8'd0, 8'h00},
        '{16'h0003, 1'b1, 1'b1, 12'h004, 8'd0, 8'd2, 8'h00},
        '{16'h0002, 1'b0, 1'b1, 12'h055, 8'd0, 8'd0, 8'h5A},
        '{16'h07FF, 1'b0, 1'b1, 12'h3C3, 8'd3, 8'd0, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, imm = 1'b0, rd_out = 1'b0;
    logic [11:0] opcode = '0;
    logic [15:0] hdr_word = '0;
    logic [19:0] in_off = 20'h1_2340, out_off = 20'hA_8000;
    logic        busy, done, tx_req, tx_rnw, tx_from_buf;
    logic [1:0]  err;
    logic [7:0]  status;
    logic [31:0] tx_addr, tx_wdata;
    logic [5:0]  tx_len;
    logic [13:0] tx_buf_off;
    logic        tx_done = 1'b0, tx_err = 1'b0;
    logic [31:0] tx_rdata = '0;

    always #2 clk = ~clk;

    mbx_cmd_seq #(.CLK_KHZ(1), .TIMEOUT_MS(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .imm(imm), .rd_out(rd_out),
        .opcode(opcode), .hdr_word(hdr_word), .in_off(in_off), .out_off(out_off),
        .busy(busy), .done(done), .err(err), .status(status),
        .tx_req(tx_req), .tx_rnw(tx_rnw), .tx_addr(tx_addr), .tx_len(tx_len),
        .tx_from_buf(tx_from_buf), .tx_buf_off(tx_buf_off), .tx_wdata(tx_wdata),
        .tx_done(tx_done), .tx_err(tx_err), .tx_rdata(tx_rdata)
    );

    int n_chk = 0, n_fail = 0;
    int lat = 2, len_v = 16;
    int wfail_left = 0, busy_left = 0, prep_fail = 0, fire_fail = 0;
    int stat_v = 0;
    int wr_att, wr_cnt, wr_bytes, rd_cnt, rd_bytes, poll_cnt, prep_cnt, fire_cnt;
    int addr_bad, len_bad, gap_bad, hold_bad;
    logic [31:0] prep_word, prep_addr, fire_word, fire_addr;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        wr_att = 0; wr_cnt = 0; wr_bytes = 0; rd_cnt = 0; rd_bytes = 0;
        poll_cnt = 0; prep_cnt = 0; fire_cnt = 0;
        addr_bad = 0; len_bad = 0; gap_bad = 0; hold_bad = 0;
        prep_word = '0; prep_addr = '0; fire_word = '0; fire_addr = '0;
    endtask

    // Responder model of the I2C master
    initial begin : master
        logic [31:0] a0;
        logic [5:0]  l0;
        int          ec;
        forever begin
            @(negedge clk);
            if (tx_req) begin
                a0 = tx_addr; l0 = tx_len;
                repeat (lat - 1) @(negedge clk);
                if (tx_addr != a0 || tx_len != l0 || !tx_req) hold_bad++;
                tx_err = 1'b0; tx_rdata = '0;
                if (tx_from_buf && !tx_rnw) begin
                    wr_att++;
                    if (tx_addr != 32'(in_off) + 32'(wr_bytes) || 32'(tx_buf_off) != 32'(wr_bytes)) addr_bad++;
                    ec = (len_v - wr_bytes > 32) ? 32 : len_v - wr_bytes;
                    if (int'(tx_len) != ec) len_bad++;
                    if (wfail_left != 0) begin
                        tx_err = 1'b1;
                        if (wfail_left > 0) wfail_left--;
                    end else begin
                        wr_cnt++; wr_bytes += int'(tx_len);
                    end
                end else if (tx_from_buf) begin
                    if (tx_addr != 32'(out_off) + 32'(rd_bytes) || 32'(tx_buf_off) != 32'(rd_bytes)) addr_bad++;
                    ec = (len_v - rd_bytes > 32) ? 32 : len_v - rd_bytes;
                    if (int'(tx_len) != ec) len_bad++;
                    rd_cnt++; rd_bytes += int'(tx_len);
                end else if (!tx_rnw && tx_len == 6'd28) begin
                    prep_cnt++; prep_word = tx_wdata; prep_addr = tx_addr;
                    tx_err = (prep_fail != 0);
                end else if (!tx_rnw) begin
                    fire_cnt++; fire_word = tx_wdata; fire_addr = tx_addr;
                    if (tx_len != 6'd4) len_bad++;
                    tx_err = (fire_fail != 0);
                end else begin
                    poll_cnt++;
                    if (tx_addr != 32'h0007_2018 || tx_len != 6'd4) addr_bad++;
                    if (busy_left != 0) begin
                        tx_rdata = 32'h0080_1234;
                        if (busy_left > 0) busy_left--;
                    end else begin
                        tx_rdata = {stat_v[7:0], 24'h01_2345};
                    end
                end
                tx_done = 1'b1;
                @(negedge clk);
                tx_done = 1'b0; tx_err = 1'b0;
                if (tx_req) gap_bad++;
            end
        end
    end

    task automatic run_cmd(input logic [15:0] h, input logic i, input logic r, input logic [11:0] o,
                           output logic [1:0] e_o, output logic [7:0] s_o);
        clear_counts();
        len_v = int'(h[10:0]) * 4 + 16;
        @(negedge clk);
        hdr_word = h; imm = i; rd_out = r; opcode = o; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
        while (!done) @(negedge clk);
        e_o = err; s_o = status;
        @(negedge clk);
        chk(!done && !busy, "R10 done pulse then idle", {done, busy}, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [1:0] e;
        logic [7:0] s;
        int n, ln, ew;
        clear_counts();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !tx_req && err == 2'd0, "R1 reset state", {busy, done, tx_req, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !tx_req, "R1 idle after reset", {busy, tx_req}, 0);

        for (int k = 0; k < 7; k++) begin
            lat = 2; wfail_left = VECS[k].wfail; busy_left = VECS[k].busyn;
            stat_v = VECS[k].stat; prep_fail = 0; fire_fail = 0;
            run_cmd(VECS[k].hdr, VECS[k].imm, VECS[k].rdo, VECS[k].opc, e, s);
            ln = int'(VECS[k].hdr[10:0]) * 4 + 16;
            n  = (ln + 31) / 32;
            ew = 32'(VECS[k].opc) | (32'(VECS[k].imm) << 12);
            chk(e == ((VECS[k].stat != 0) ? 2'd3 : 2'd0), $sformatf("R5 err vec%0d", k), e, (VECS[k].stat != 0) ? 3 : 0);
            chk(s == VECS[k].stat, $sformatf("R5 status vec%0d", k), s, VECS[k].stat);
            chk(wr_cnt == (VECS[k].imm ? 0 : n) && wr_bytes == (VECS[k].imm ? 0 : ln),
                $sformatf("R2 R7 write chunks vec%0d", k), wr_bytes, VECS[k].imm ? 0 : ln);
            chk(wr_att == (VECS[k].imm ? 0 : n + int'(VECS[k].wfail)),
                $sformatf("R8 write attempts vec%0d", k), wr_att, VECS[k].imm ? 0 : n + int'(VECS[k].wfail));
            chk(prep_word == ew && prep_addr == 32'h0007_2000, $sformatf("R3 prepare vec%0d", k), prep_word, ew);
            chk(fire_word == (ew | 32'h0080_0000) && fire_addr == 32'h0007_2018,
                $sformatf("R4 fire vec%0d", k), fire_word, ew | 32'h0080_0000);
            chk(poll_cnt == int'(VECS[k].busyn) + 1, $sformatf("R5 polls vec%0d", k), poll_cnt, int'(VECS[k].busyn) + 1);
            chk(rd_bytes == ((!VECS[k].imm && VECS[k].rdo && VECS[k].stat == 0) ? ln : 0) &&
                rd_cnt == ((!VECS[k].imm && VECS[k].rdo && VECS[k].stat == 0) ? n : 0),
                $sformatf("R6 readback vec%0d", k), rd_bytes,
                (!VECS[k].imm && VECS[k].rdo && VECS[k].stat == 0) ? ln : 0);
            chk(addr_bad == 0 && len_bad == 0, $sformatf("R2 chunk addr/len vec%0d", k), addr_bad + len_bad, 0);
            chk(gap_bad == 0 && hold_bad == 0, $sformatf("R11 handshake vec%0d", k), gap_bad + hold_bad, 0);
        end

        // R8: chunk write never succeeds; first failure lands after expiry
        lat = 40; wfail_left = -1; busy_left = 0; stat_v = 0;
        run_cmd(16'h0000, 1'b0, 1'b0, 12'h011, e, s);
        chk(e == 2'd1, "R8 write give-up err", e, 1);
        chk(wr_att == 6, "R8 write attempts after timeout", wr_att, 6);
        chk(prep_cnt == 0, "R8 no prepare after give-up", prep_cnt, 0);

        // R8: busy bit never clears
        lat = 40; wfail_left = 0; busy_left = -1;
        run_cmd(16'h0000, 1'b0, 1'b1, 12'h012, e, s);
        chk(e == 2'd2, "R8 poll timeout err", e, 2);
        chk(poll_cnt == 6, "R8 poll attempts after timeout", poll_cnt, 6);
        chk(rd_cnt == 0, "R8 no readback after timeout", rd_cnt, 0);

        // R9: prepare fails
        lat = 2; busy_left = 0; prep_fail = 1;
        run_cmd(16'h0001, 1'b0, 1'b1, 12'h013, e, s);
        chk(e == 2'd1 && prep_cnt == 1, "R9 prepare failure", {e, prep_cnt[7:0]}, {2'd1, 8'd1});
        chk(fire_cnt == 0 && poll_cnt == 0, "R9 nothing after prepare failure", fire_cnt + poll_cnt, 0);
        prep_fail = 0; fire_fail = 1;
        run_cmd(16'h0001, 1'b0, 1'b1, 12'h014, e, s);
        chk(e == 2'd1 && fire_cnt == 1 && poll_cnt == 0, "R9 fire failure", {e, poll_cnt[7:0]}, {2'd1, 8'd0});
        fire_fail = 0;

        // R10: start while busy is ignored
        clear_counts();
        len_v = 16 + 5 * 4;
        @(negedge clk);
        hdr_word = 16'h0005; imm = 1'b0; rd_out = 1'b0; opcode = 12'h0A5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        opcode = 12'hFFF; imm = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(prep_word == 32'h0A5 && prep_cnt == 1, "R10 start while busy ignored", prep_word, 32'h0A5);
        chk(!busy && !tx_req, "R10 no second command", {busy, tx_req}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule